// File: doc/BRIEF.md
# Latched Interval Timer

This block is a down-counting interval timer with a 16-bit count and a separate reload latch. A parameterised prescaler turns the input clock into a count tick, one tick every `DIV` clocks (six by default). Software loads the count and the latch one byte at a time, through a narrow write port decoded by a neighbouring register block. The same neighbour owns the control register. It supplies a two-bit mode field, and it stores the interrupt flag that this timer sets with a one-cycle expiry pulse.

In continuous mode (mode `01`), the timer fires whenever the count is zero on a tick, and it reloads so that every later expiry comes one latch period after the one before. In any other mode it fires once per count load and then keeps decrementing through the wrap without firing again. The live count is always visible on a read-back port, so the neighbour can return either byte.

Top module: `lit_timer`

## Requirements
- R1: A write with select `00` replaces count bits [7:0] with the data byte, keeps the live bits [15:8], and restarts the prescaler so a full DIV clocks pass before the next tick.
- R2: A write with select `01` replaces count bits [15:8] with the data byte, keeps the live bits [7:0], and restarts the prescaler the same way.
- R3: Writes with select `10` (bits [7:0]) and `11` (bits [15:8]) change only their half of the latch and clear latch bit 16. They do not restart the count, and the next reload uses the new value.
- R4: With mode `01`, an expiry pulse is raised one cycle after a tick that finds the count at zero. The count then reads latch minus one (modulo 2^16), so later expiries come every latch-value ticks.
- R5: After a count load of value V, the first expiry pulse is high in the cycle that follows the V+1-th tick, which is DIV*(V+1) clocks after the write edge.
- R6: With mode not `01`, only the first expiry after a count load produces a pulse. The count then wraps to 0xFFFF and keeps decrementing with no further pulse.
- R7: The mode input is evaluated at the tick itself. Leaving mode `01` suppresses the next zero-count expiry with no latency.
- R8: After reset the count reads 0xFFFF, no pulse is raised, and the latch holds 0x10000, so a continuous-mode reload from it reads 0xFFFF.
- R9: Between writes, the count decreases by one every DIV clocks.
- R10: The expiry pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Write target: 00 count low, 01 count high, 10 latch low, 11 latch high |
| wr_data | input | 8 | Write byte |
| mode | input | 2 | Mode field from the control register; `01` is continuous |
| count_o | output | 16 | Live count read-back |
| expire_o | output | 1 | One-cycle expiry pulse to the flag register |

## Verification
A corrupted count, or a prescaler phase that drifts, moves the expiry pulse by whole multiples of DIV clocks. Such a fault shows at the first expiry after a load, at most DIV*(V+1) clocks in, so the bench compares the pulse against an arithmetic schedule on every cycle of each window. A wrong latch or a wrong reload value shows at the first reload, in the count read-back and in the spacing of the second pulse. A stuck one-shot arm shows as an extra pulse one latch period later.

// File: rtl/lit_pkg.sv
// Shared types for the latched interval timer.
package lit_pkg;
    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_LAT_LO = 2'd2,
        SEL_LAT_HI = 2'd3
    } wr_sel_e;

    localparam logic [1:0] MODE_CONT = 2'b01;
endpackage

// File: rtl/lit_prescaler.sv
// Tick generator: raises tick once every DIV clocks.
// Assumes DIV >= 2. A restart puts the phase back to zero and suppresses
// the tick in that cycle.
module lit_prescaler #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Tick when the phase reaches its last value, unless a restart is pending.
    assign tick = (phase == LAST) && !restart;

    // Advance the phase, wrapping at DIV or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                         phase <= '0;
        else if (restart || phase == LAST)  phase <= '0;
        else                                phase <= phase + 1'b1;
    end

    // R9
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
    // R1
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/lit_latch.sv
// Reload latch: one bit wider than the count, so that the reset value
// 2^CNT_W can be held. Byte writes touch only their half and clear the top bit.
module lit_latch #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic [CNT_W:0]     latch_o
);
    localparam int HALF_W = CNT_W / 2;

    // Hold or update one half of the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_o <= {1'b1, {CNT_W{1'b0}}};
        else if (wr_lo) latch_o <= {1'b0, latch_o[CNT_W-1:HALF_W], wr_data};
        else if (wr_hi) latch_o <= {1'b0, wr_data, latch_o[HALF_W-1:0]};
    end

    // R3
    latch_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (latch_o[CNT_W-1:HALF_W] == $past(latch_o[CNT_W-1:HALF_W])) && !latch_o[CNT_W]);
    // R3
    latch_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (latch_o[HALF_W-1:0] == $past(latch_o[HALF_W-1:0])) && !latch_o[CNT_W]);
endmodule

// File: rtl/lit_count.sv
// Down counter with byte-merge loads, reload from the latch in continuous
// mode, and a one-shot arm that allows a single expiry per load otherwise.
// Assumes the tick is never high in a cycle that carries a count write.
module lit_count #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               tick,
    input  logic               cont_mode,
    input  logic [CNT_W:0]     latch_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               expire_o
);
    localparam int HALF_W = CNT_W / 2;

    logic             at_zero;
    logic             armed;
    logic             fire;
    logic [CNT_W-1:0] reload;

    // Expiry is decided at the tick, using the mode of that cycle.
    always_comb begin
        at_zero = (count_o == '0);
        fire    = tick && at_zero && (cont_mode || armed);
        reload  = CNT_W'(latch_i - 1'b1);
    end

    // Count, arm and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o  <= '1;
            armed    <= 1'b0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= fire;
            if (wr_lo) begin
                count_o <= {count_o[CNT_W-1:HALF_W], wr_data};
                armed   <= 1'b1;
            end else if (wr_hi) begin
                count_o <= {wr_data, count_o[HALF_W-1:0]};
                armed   <= 1'b1;
            end else if (tick) begin
                count_o <= (at_zero && cont_mode) ? reload : count_o - 1'b1;
                if (at_zero) armed <= 1'b0;
            end
        end
    end

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    // R4
    cont_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && $past(cont_mode)) |-> (count_o + 1'b1 == $past(latch_i[CNT_W-1:0])));
    // R6
    oneshot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !$past(cont_mode)) |-> (count_o == '1));
    // R1
    cnt_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W])));
    // R5
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(tick));
endmodule

// File: rtl/lit_timer.sv
// Latched interval timer top: decodes the byte-write select, and joins the
// prescaler, reload latch and counter. The register decode and flag storage
// live in the neighbouring register block.
module lit_timer #(
    parameter int CNT_W = 16,
    parameter int DIV   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic [1:0]         mode,
    output logic [CNT_W-1:0]   count_o,
    output logic               expire_o
);
    import lit_pkg::*;

    logic           cnt_lo_we, cnt_hi_we, lat_lo_we, lat_hi_we;
    logic           tick;
    logic           cont_mode;
    logic [CNT_W:0] latch_q;

    // Decode the write select into one strobe per target.
    always_comb begin
        cnt_lo_we = 1'b0;
        cnt_hi_we = 1'b0;
        lat_lo_we = 1'b0;
        lat_hi_we = 1'b0;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_CNT_LO: cnt_lo_we = 1'b1;
                SEL_CNT_HI: cnt_hi_we = 1'b1;
                SEL_LAT_LO: lat_lo_we = 1'b1;
                default:    lat_hi_we = 1'b1;
            endcase
        end
        cont_mode = (mode == MODE_CONT);
    end

    lit_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_lo_we | cnt_hi_we),
        .tick    (tick)
    );

    lit_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (lat_lo_we),
        .wr_hi   (lat_hi_we),
        .wr_data (wr_data),
        .latch_o (latch_q)
    );

    lit_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (cnt_lo_we),
        .wr_hi     (cnt_hi_we),
        .wr_data   (wr_data),
        .tick      (tick),
        .cont_mode (cont_mode),
        .latch_i   (latch_q),
        .count_o   (count_o),
        .expire_o  (expire_o)
    );

    // R8
    reset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == {1'b1, {CNT_W{1'b0}}}) && (count_o == '1));
    // R7
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o == '0 && !cont_mode) |=> (count_o == '1));
endmodule

// File: tb/lit_timer_tb.sv
module lit_timer_tb;
    localparam int DIV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] count_o;
    logic        expire_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mode(mode), .count_o(count_o), .expire_o(expire_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the write edge is the next rising edge.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Window after a count load of V: pulses and read-back per cycle.
    task automatic run_window(input int v, input int lat, input bit cont, input int n);
        int first = DIV * (v + 1);
        for (int k = 1; k <= n; k++) begin
            bit exp_p;
            @(negedge clk);
            if (cont) exp_p = (k >= first) && (((k - first) % (DIV * lat)) == 0);
            else      exp_p = (k == first);
            chk(expire_o == exp_p, cont ? "R4/R5/R10 pulse" : "R6/R5/R10 pulse",
                int'(expire_o), int'(exp_p));
            if (k < first)
                chk(count_o == 16'(v - k / DIV), "R9 count", count_o, v - k / DIV);
            if (cont && exp_p)
                chk(count_o == 16'(lat - 1), "R4 reload", count_o, lat - 1);
            if (!cont && k == first + 3 * DIV)
                chk(count_o == 16'hFFFC, "R6 wrap", count_o, 16'hFFFC);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count_o == 16'hFFFF, "R8 reset count", count_o, 16'hFFFF);
        chk(expire_o == 1'b0, "R8 reset pulse", int'(expire_o), 0);

        // Reset latch reload and byte merges
        mode = 2'b01;
        wr(2'd0, 8'h01);
        chk(count_o == 16'hFF01, "R1 low merge", count_o, 16'hFF01);
        wr(2'd1, 8'h00);
        chk(count_o == 16'h0001, "R2 high merge", count_o, 16'h0001);
        for (int k = 1; k <= 2 * DIV; k++) begin
            @(negedge clk);
            chk(expire_o == (k == 2 * DIV), "R5 first pulse", int'(expire_o), int'(k == 2 * DIV));
        end
        chk(count_o == 16'hFFFF, "R8 reset latch reload", count_o, 16'hFFFF);

        // Low latch write alone clears the top bit: reload 2, period 3 ticks
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        run_window(0, 3, 1'b1, 40);

        // Sweep: continuous and one-shot loads
        for (int v = 0; v <= 4; v++) begin
            for (int lat = 1; lat <= 4; lat++) begin
                mode = 2'b01;
                wr(2'd2, 8'(lat));
                wr(2'd3, 8'h00);
                wr(2'd0, 8'(v));
                wr(2'd1, 8'h00);
                run_window(v, lat, 1'b1, DIV * (v + 1) + DIV * lat * 3);
            end
            for (int m = 0; m <= 3; m++) begin
                if (m == 1) continue;
                mode = 2'(m);
                wr(2'd0, 8'(v));
                wr(2'd1, 8'h00);
                run_window(v, 1, 1'b0, DIV * (v + 1) + DIV * 4);
            end
        end

        // Mode leaves continuous after the first pulse (latch 2, V 0)
        mode = 2'b01;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            chk(expire_o == (k == DIV), "R7 pulse", int'(expire_o), int'(k == DIV));
            if (k == DIV) mode = 2'b00;
            if (k == 3 * DIV) chk(count_o == 16'hFFFF, "R7 no reload", count_o, 16'hFFFF);
        end

        // Latch rewrite mid-run (latch 4 -> 2): pulses at 6, 30, 42
        mode = 2'b01;
        wr(2'd2, 8'h04);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        for (int k = 1; k <= 50; k++) begin
            bit e;
            @(negedge clk);
            e = (k == 6) || (k == 30) || (k == 42);
            chk(expire_o == e, "R3 new latch pulse", int'(expire_o), int'(e));
            if (k == 7) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h02; end
            if (k == 8) begin
                wr_en = 1'b0;
                chk(count_o == 16'd3, "R3 no restart", count_o, 3);
            end
            if (k == 30) chk(count_o == 16'd1, "R3 reload", count_o, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule